// File: doc/BRIEF.md
# Reloadable 24-bit System Tick Timer

This block is a periodic down-counting timer that sits on a simple word-addressed register bus. Software sets a 24-bit reload value and selects the count source: every core clock cycle, or the rising edges of an external reference tick. Software then enables the counter. The counter steps down by one per source tick. When it steps from 1 to 0 it sets a sticky status flag. If enabled, it also raises a one-cycle interrupt request toward the interrupt controller. On the next tick it reloads and the cycle repeats.

The external reference is an asynchronous level. It is brought into the core clock domain through a synchronizer, and each rising edge gives one count step. A write of any value to the current-value register forces the counter to zero and clears the status flag. A read of the control/status register returns the flag and then clears it. A read-only calibration word reports a constant set at build time.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current-value registers all read 0 and `irq` is low.
- R2: When the control/status register has bit 0 (run) = 1 and bit 2 (source) = 1, the counter is in core-clock mode and decreases by exactly one per core clock cycle.
- R3: When the counter steps from 1 to 0, control/status bit 16 (wrap flag) is set.
- R4: A tick that finds the counter at 0 loads the reload value. With a reload value of 0, the counter stays at 0 and the wrap flag is never set.
- R5: `irq` is high for exactly one cycle, the cycle in which the counter first reads 0 after a 1-to-0 step, and only when control/status bit 1 (interrupt enable) was set.
- R6: A read of the control/status register (offset 0x010) returns the wrap flag and clears it afterwards. A flag being set in the same cycle as the read is kept.
- R7: A write of any value to the current-value register (offset 0x018) sets the counter to 0 and clears the wrap flag, taking priority over any tick in that cycle.
- R8: With bit 0 = 1 and bit 2 = 0, the counter is in external mode and steps once per rising edge of `ref_tick`, seen after a two-stage synchronizer. A level held high gives only one step.
- R9: The reload register (offset 0x014) stores only data bits 23:0. The reload and current-value registers read bits 31:24 as 0.
- R10: The calibration word at offset 0x01C reads `CALIB_VALUE`, and writes to it have no effect.
- R11: While bit 0 = 0, the counter holds its value.
- R12: Reads of any offset other than 0x010, 0x014, 0x018 and 0x01C return 0. `bus_rdata` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Asynchronous external reference tick |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 24 | Write data (only the writable bits) |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| irq | output | 1 | One-cycle interrupt request on wrap to zero |

## Verification
The hardest case to reach from the ports is a status read that lands in the very cycle the counter steps from 1 to 0. In that cycle the set and the clear of the flag collide. To force it, the stimulus uses a reload value of 2 in core-clock mode and issues back-to-back status reads, so every third read coincides with a wrap. A second hard case is a current-value write that meets a live tick. It is reached by writing the register at several offsets into a short count period.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int PKG_ADDR_W = 12;

    localparam logic [PKG_ADDR_W-1:0] OFS_CTRL   = 12'h010;
    localparam logic [PKG_ADDR_W-1:0] OFS_RELOAD = 12'h014;
    localparam logic [PKG_ADDR_W-1:0] OFS_CUR    = 12'h018;
    localparam logic [PKG_ADDR_W-1:0] OFS_CALIB  = 12'h01C;

    localparam int BIT_RUN  = 0;
    localparam int BIT_IEN  = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_WRAP = 16;

    typedef struct packed {
        logic core_src;
        logic ien;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d    = sh_q;
        sh_d[0] = ref_in;
        for (int i = 1; i < DEPTH; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R8: one rising edge gives a single-cycle step enable
    p_single_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ien,
    input  logic             step,
    input  logic             clear,
    input  logic             flag_rd,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             irq;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_t st_d, st_q;
    logic       hit_zero;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        hit_zero = 1'b0;
        if (clear) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else begin
            if (run && step) begin
                if (st_q.cnt == '0) begin
                    st_d.cnt = reload;
                end else if (st_q.cnt == ONE) begin
                    st_d.cnt = '0;
                    hit_zero = 1'b1;
                    st_d.irq = ien;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            if (hit_zero)     st_d.flag = 1'b1;
            else if (flag_rd) st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;

    // R3: a live 1-to-0 step leaves the flag set
    p_wrap_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !clear && cnt_o == ONE) |=> flag_o);

    // R4: a tick at zero loads the reload value that was present
    p_zero_reloads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !clear && cnt_o == '0) |=> cnt_o == $past(reload));

    // R5: the request only accompanies a zero count and lasts one cycle
    p_irq_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cnt_o == '0);
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R7: a current-value write zeroes count and flag
    p_cur_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_o == '0 && !flag_o));

    // R11: a stopped counter keeps its value
    p_stopped_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt_o));

endmodule

// File: rtl/tick_reg_if.sv
module tick_reg_if
    import tick_timer_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          DATA_W      = 32,
    parameter int          CNT_W       = 24,
    parameter logic [31:0] CALIB_VALUE = 32'h0000_4E20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              flag_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              cur_wr_o,
    output logic              ctrl_rd_o
);
    localparam int PAD_W = DATA_W - CNT_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
    } reg_state_t;

    reg_state_t rs_d, rs_q;
    logic       hit_ctrl, hit_reload, hit_cur, hit_calib;
    logic       do_wr, do_rd;

    always_comb begin
        hit_ctrl   = bus_addr == ADDR_W'(OFS_CTRL);
        hit_reload = bus_addr == ADDR_W'(OFS_RELOAD);
        hit_cur    = bus_addr == ADDR_W'(OFS_CUR);
        hit_calib  = bus_addr == ADDR_W'(OFS_CALIB);
        do_wr      = bus_sel &  bus_wr;
        do_rd      = bus_sel & ~bus_wr;
    end

    always_comb begin
        rs_d = rs_q;
        if (do_wr && hit_ctrl) begin
            rs_d.ctrl.run      = bus_wdata[BIT_RUN];
            rs_d.ctrl.ien      = bus_wdata[BIT_IEN];
            rs_d.ctrl.core_src = bus_wdata[BIT_SRC];
        end
        if (do_wr && hit_reload) begin
            rs_d.reload = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (do_rd) begin
            if (hit_ctrl) begin
                bus_rdata[BIT_RUN]  = rs_q.ctrl.run;
                bus_rdata[BIT_IEN]  = rs_q.ctrl.ien;
                bus_rdata[BIT_SRC]  = rs_q.ctrl.core_src;
                bus_rdata[BIT_WRAP] = flag_i;
            end else if (hit_reload) begin
                bus_rdata = {{PAD_W{1'b0}}, rs_q.reload};
            end else if (hit_cur) begin
                bus_rdata = {{PAD_W{1'b0}}, cnt_i};
            end else if (hit_calib) begin
                bus_rdata = DATA_W'(CALIB_VALUE);
            end
        end
    end

    assign ctrl_o    = rs_q.ctrl;
    assign reload_o  = rs_q.reload;
    assign cur_wr_o  = do_wr & hit_cur;
    assign ctrl_rd_o = do_rd & hit_ctrl;

    // R9: count-wide registers never show upper bits
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && (hit_reload || hit_cur)) |-> bus_rdata[DATA_W-1:CNT_W] == '0);

    // R10: calibration word is fixed whatever was written before
    p_calib_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && hit_calib) |-> bus_rdata == DATA_W'(CALIB_VALUE));

    // R12: no read in progress gives a quiet data bus
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !do_rd |-> bus_rdata == '0);

endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
    import tick_timer_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          DATA_W      = 32,
    parameter int          CNT_W       = 24,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] CALIB_VALUE = 32'h0000_4E20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             flag;
    logic             cur_wr;
    logic             ctrl_rd;
    logic             ext_rise;
    logic             step;

    tick_ref_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_tick),
        .rise_o (ext_rise)
    );

    tick_reg_if #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .CALIB_VALUE (CALIB_VALUE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_i     (cnt),
        .flag_i    (flag),
        .ctrl_o    (ctrl),
        .reload_o  (reload),
        .cur_wr_o  (cur_wr),
        .ctrl_rd_o (ctrl_rd)
    );

    assign step = ctrl.core_src ? 1'b1 : ext_rise;

    tick_down_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .ien     (ctrl.ien),
        .step    (step),
        .clear   (cur_wr),
        .flag_rd (ctrl_rd),
        .reload  (reload),
        .cnt_o   (cnt),
        .flag_o  (flag),
        .irq_o   (irq)
    );

    // R5: no request may leave while interrupts were disabled
    p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctrl.ien));

endmodule

// File: tb/periodic_tick_timer_bench.sv
`timescale 1ns/1ps
module periodic_tick_timer_bench;
    localparam logic [31:0] CALIB = 32'h0000_4E20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h018;
    logic [23:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    periodic_tick_timer #(.CALIB_VALUE(CALIB)) u_periodic_tick_timer (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit          m_run = 0, m_ien = 0, m_src = 0, m_flag = 0, m_irq = 0;
    int unsigned m_reload = 0, m_cnt = 0;
    bit          h1 = 0, h2 = 0, h3 = 0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read();
        logic [31:0] v = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                12'h010: v = {15'd0, m_flag, 13'd0, m_src, m_ien, m_run};
                12'h014: v = m_reload;
                12'h018: v = m_cnt;
                12'h01C: v = CALIB;
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    // compare at the falling edge, then predict the next rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit tick, hit, rd_ctrl, wr_cur;
            check(cur_req, "rdata", bus_rdata, model_read());
            check(cur_req, "irq", {31'd0, irq}, {31'd0, m_irq});
            tick    = m_src ? 1'b1 : (h2 && !h3);
            h3 = h2; h2 = h1; h1 = ref_tick;
            rd_ctrl = bus_sel && !bus_wr && bus_addr == 12'h010;
            wr_cur  = bus_sel && bus_wr && bus_addr == 12'h018;
            hit     = 0;
            m_irq   = 0;
            if (wr_cur) begin
                m_cnt = 0; m_flag = 0;
            end else begin
                if (m_run && tick) begin
                    if (m_cnt == 0) m_cnt = m_reload;
                    else if (m_cnt == 1) begin m_cnt = 0; hit = 1; m_irq = m_ien; end
                    else m_cnt = m_cnt - 1;
                end
                if (hit) m_flag = 1;
                else if (rd_ctrl) m_flag = 0;
            end
            if (bus_sel && bus_wr && bus_addr == 12'h010) begin
                m_run = bus_wdata[0]; m_ien = bus_wdata[1]; m_src = bus_wdata[2];
            end
            if (bus_sel && bus_wr && bus_addr == 12'h014) m_reload = bus_wdata;
        end
    end

    task automatic idle_bus();
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h018; bus_wdata = '0;
    endtask

    task automatic cycles(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr_reg(logic [11:0] a, logic [23:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cycles(1);
        idle_bus();
    endtask

    task automatic rd_reg(logic [11:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        cycles(1);
        idle_bus();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        idle_bus();
        // R1: reset values
        cur_req = "R1";
        rd_reg(12'h010); rd_reg(12'h014); rd_reg(12'h018); cycles(2);
        // R9: only 24 bits of reload are kept
        cur_req = "R9";
        wr_reg(12'h014, 24'hFFFFFF); rd_reg(12'h014);
        wr_reg(12'h014, 24'd5); rd_reg(12'h014);
        // R2, R3, R5: core clock, interrupts on
        cur_req = "R2";
        wr_reg(12'h010, 24'h000007);
        cycles(9);
        cur_req = "R3";
        rd_reg(12'h010); rd_reg(12'h010);
        cur_req = "R5";
        cycles(14);
        // R6: status reads that coincide with wraps
        cur_req = "R6";
        wr_reg(12'h014, 24'd2);
        for (int i = 0; i < 12; i++) rd_reg(12'h010);
        // R7: current-value writes at several phases
        cur_req = "R7";
        wr_reg(12'h014, 24'd4);
        for (int k = 0; k < 6; k++) begin
            cycles(k);
            wr_reg(12'h018, 24'hABCDEF);
            rd_reg(12'h010);
        end
        // R11: stopped counter holds
        cur_req = "R11";
        wr_reg(12'h014, 24'd30); cycles(6);
        wr_reg(12'h010, 24'h000006); cycles(10);
        // R5: no request with interrupt enable clear
        cur_req = "R5";
        wr_reg(12'h014, 24'd3);
        wr_reg(12'h010, 24'h000005); cycles(15); rd_reg(12'h010);
        // R8: external reference with varied high/low lengths
        cur_req = "R8";
        wr_reg(12'h014, 24'd3);
        wr_reg(12'h010, 24'h000003);
        for (int k = 0; k < 10; k++) begin
            ref_tick = 1'b1; cycles(1 + (k % 4));
            ref_tick = 1'b0; cycles(1 + ((k * 3) % 5));
        end
        rd_reg(12'h010); cycles(4);
        // R4: reload of zero stays idle
        cur_req = "R4";
        wr_reg(12'h010, 24'h000007);
        wr_reg(12'h014, 24'd0);
        wr_reg(12'h018, 24'd0);
        cycles(10); rd_reg(12'h010);
        // R10: calibration word read-only
        cur_req = "R10";
        rd_reg(12'h01C); wr_reg(12'h01C, 24'h123456); rd_reg(12'h01C);
        // R12: unmapped offsets and no-access bus
        cur_req = "R12";
        rd_reg(12'h020); rd_reg(12'h000); rd_reg(12'h011);
        bus_sel = 1'b0; cycles(3); idle_bus(); cycles(1);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog (R2): actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule